// File: doc/BRIEF.md
# Fetch Next-Address Predictor

This block sits in the fetch stage of a dual-issue in-order core. In every cycle it looks up the current fetch address and returns the address from which fetch should continue. Fetch reads an aligned 8-byte group, so without a known branch the next address is the start of the following group. Known branches are kept in a two-way set-associative target buffer with 512 entries. Return branches take their target from an 8-deep return-address stack. When the target buffer has no entry, a 4096-entry table of two-bit counters, indexed by the address XORed with a global history register, gives a taken/not-taken hint for the decode stage. In that case the next address stays sequential.

A resolved branch comes back through the update port. The port carries the branch address, its kind, its outcome, its target, and the next address that fetch used after it. The block trains its tables from this report. If the address fetch used was wrong, it raises a one-cycle flush together with the correct restart address. The history register and the return stack change only at resolution. They are not repaired speculatively.

Top module: `bp_next_pc`

## Requirements
- R1: After reset, every fetch address misses (`pred_hit`=0), `pred_taken`=0 and `flush`=0.
- R2: On a miss, `pred_next_pc` equals the fetch address with its low 3 bits cleared, plus 8, wrapping at 2^32.
- R3: A target-buffer entry is selected by address bits [9:2] and tagged by bits [31:10]. On a hit of a conditional (kind 0) or call (kind 1) entry, the block reports `pred_hit`=1 and `pred_taken`=1, and `pred_next_pc` is the stored target.
- R4: A taken branch that misses is written into the least-recently-used way of its set. Any accepted update that hits makes the other way LRU. A conditional reported not taken that hits is invalidated, and its way becomes LRU.
- R5: On a miss, `pred_taken` is the upper bit of a two-bit saturating counter at index (address bits [13:2]) XOR the 12-bit history. Counters reset to 01. Each accepted conditional moves its counter up if taken and down if not, then shifts its outcome into bit 0 of the history.
- R6: An accepted call (kind 1) pushes its address + 4. An accepted return (kind 2) pops. A fetch that hits a return entry predicts the top of the stack.
- R7: The stack holds 8 entries, and a ninth push overwrites the oldest. A return hit on an empty stack gives the sequential address with `pred_taken`=0.
- R8: For an accepted update, the correct next address is the target if taken and address + 4 otherwise. If it differs from `upd_pred_pc`, `flush` is 1 in the next cycle and `redirect_pc` holds the correct address. Otherwise `flush` stays 0.
- R9: `flush` lasts exactly one cycle. An update presented while `flush` is 1 is ignored completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Current fetch address |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Predicted direction (hint from history table on a miss) |
| pred_hit | output | 1 | Target buffer holds the fetch address |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_kind | input | 2 | 0 conditional, 1 call, 2 return |
| upd_taken | input | 1 | Resolved outcome |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target |
| upd_pred_pc | input | 32 | Next address fetch used after this branch |
| flush | output | 1 | One-cycle pipeline flush request |
| redirect_pc | output | 32 | Restart address, valid while flush is 1 |

## Verification
A stale or wrongly replaced entry in the target buffer shows up the first time its address is fetched: `pred_hit` or `pred_next_pc` is wrong in that same cycle. A bad LRU bit stays hidden until a third branch maps to the set, and the wrong survivor then shows on the next fetch. An error in the history register or in a counter appears only on `pred_taken` for a later miss whose index lands on that counter. A return-stack pointer error appears on the next fetch of a return entry, one cycle after the push or pop. Flush mistakes are visible one cycle after the update that caused them.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_CALL = 2'd1,
        BK_RET  = 2'd2,
        BK_RSVD = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bp_target_buf.sv
// Two-way set-associative branch target store with one LRU bit per set.
module bp_target_buf
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-3:0]   lk_word,
    output logic              lk_hit,
    output br_kind_e          lk_kind,
    output logic [PC_W-1:0]   lk_target,
    input  logic              up_en,
    input  br_kind_e          up_kind,
    input  logic              up_taken,
    input  logic [PC_W-3:0]   up_word,
    input  logic [PC_W-1:0]   up_target
);
    localparam int WAYS  = 2;
    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - 2 - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][PC_W-1:0]   target;
        logic [SETS-1:0][WAYS-1:0][1:0]        kind;
        logic [SETS-1:0]                       lru;
    } btb_st_t;

    btb_st_t st_d, st_q;

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic [WAYS-1:0]  l_match, u_match;
    logic             l_way, u_way, victim;

    assign l_idx = lk_word[IDX_W-1:0];
    assign l_tag = lk_word[PC_W-3 -: TAG_W];
    assign u_idx = up_word[IDX_W-1:0];
    assign u_tag = up_word[PC_W-3 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign l_match[w] = st_q.valid[l_idx][w] && (st_q.tag[l_idx][w] == l_tag);
        assign u_match[w] = st_q.valid[u_idx][w] && (st_q.tag[u_idx][w] == u_tag);
    end

    assign l_way     = l_match[1];
    assign lk_hit    = |l_match;
    assign lk_target = st_q.target[l_idx][l_way];
    assign lk_kind   = br_kind_e'(st_q.kind[l_idx][l_way]);

    always_comb begin
        st_d   = st_q;
        u_way  = u_match[1];
        victim = st_q.lru[u_idx];
        if (up_en) begin
            if (|u_match) begin
                if (up_kind == BK_COND && !up_taken) begin
                    st_d.valid[u_idx][u_way] = 1'b0;
                    st_d.lru[u_idx]          = u_way;
                end else if (up_taken) begin
                    st_d.target[u_idx][u_way] = up_target;
                    st_d.kind[u_idx][u_way]   = up_kind;
                    st_d.lru[u_idx]           = ~u_way;
                end
            end else if (up_taken) begin
                st_d.valid[u_idx][victim]  = 1'b1;
                st_d.tag[u_idx][victim]    = u_tag;
                st_d.target[u_idx][victim] = up_target;
                st_d.kind[u_idx][victim]   = up_kind;
                st_d.lru[u_idx]            = ~victim;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bp_dir_table.sv
// Global-history direction table of two-bit saturating counters.
module bp_dir_table #(
    parameter int ENTRIES = 4096
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(ENTRIES)-1:0]  lk_bits,
    output logic                        lk_taken,
    input  logic                        up_en,
    input  logic [$clog2(ENTRIES)-1:0]  up_bits,
    input  logic                        up_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [IDX_W-1:0]         ghr;
        logic [ENTRIES-1:0][1:0]  ctr;
    } dir_st_t;

    dir_st_t st_d, st_q;

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [1:0]       cur;

    assign l_idx    = lk_bits ^ st_q.ghr;
    assign u_idx    = up_bits ^ st_q.ghr;
    assign lk_taken = st_q.ctr[l_idx][1];
    assign cur      = st_q.ctr[u_idx];

    always_comb begin
        st_d = st_q;
        if (up_en) begin
            if (up_taken && cur != 2'b11)       st_d.ctr[u_idx] = cur + 2'd1;
            else if (!up_taken && cur != 2'b00) st_d.ctr[u_idx] = cur - 2'd1;
            st_d.ghr = {st_q.ghr[IDX_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ghr <= '0;
            st_q.ctr <= {ENTRIES{2'b01}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bp_ret_stack.sv
// Circular return-address stack; overflow drops the oldest entry.
module bp_ret_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_val,
    input  logic            pop,
    output logic            top_valid,
    output logic [PC_W-1:0] top_val
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } ras_st_t;

    ras_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
    endfunction

    assign top_valid = (st_q.cnt != '0);
    assign top_val   = st_q.mem[ptr_dec(st_q.ptr)];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.ptr] = push_val;
            st_d.ptr           = ptr_inc(st_q.ptr);
            if (st_q.cnt != CNT_W'(DEPTH)) st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop && st_q.cnt != '0) begin
            st_d.ptr = ptr_dec(st_q.ptr);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bp_next_pc.sv
// Fetch next-address predictor: target buffer, history fallback, return stack.
module bp_next_pc
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int BTB_ENTRIES = 512,
    parameter int GHT_ENTRIES = 4096,
    parameter int RAS_DEPTH   = 8,
    parameter int FETCH_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_taken,
    output logic            pred_hit,
    input  logic            upd_valid,
    input  logic [1:0]      upd_kind,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic [PC_W-1:0] upd_pred_pc,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);
    localparam int              GIDX_W    = $clog2(GHT_ENTRIES);
    localparam logic [PC_W-1:0] FETCH_INC = PC_W'(FETCH_BYTES);
    localparam logic [PC_W-1:0] GRP_MASK  = ~(FETCH_INC - PC_W'(1));
    localparam logic [PC_W-1:0] INSN_INC  = PC_W'(4);

    typedef struct packed {
        logic            flush;
        logic [PC_W-1:0] redirect;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    br_kind_e        kind;
    logic            accept;
    logic [PC_W-1:0] seq_pc, upd_correct;
    logic            btb_hit, ght_taken, ras_valid;
    br_kind_e        btb_kind;
    logic [PC_W-1:0] btb_target, ras_top;

    assign kind        = br_kind_e'(upd_kind);
    assign accept      = upd_valid && !ctl_q.flush;
    assign upd_correct = upd_taken ? upd_target : (upd_pc + INSN_INC);

    bp_target_buf #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_word   (fetch_pc[PC_W-1:2]),
        .lk_hit    (btb_hit),
        .lk_kind   (btb_kind),
        .lk_target (btb_target),
        .up_en     (accept),
        .up_kind   (kind),
        .up_taken  (upd_taken),
        .up_word   (upd_pc[PC_W-1:2]),
        .up_target (upd_target)
    );

    bp_dir_table #(.ENTRIES(GHT_ENTRIES)) u_ght (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bits  (fetch_pc[2 +: GIDX_W]),
        .lk_taken (ght_taken),
        .up_en    (accept && kind == BK_COND),
        .up_bits  (upd_pc[2 +: GIDX_W]),
        .up_taken (upd_taken)
    );

    bp_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && kind == BK_CALL),
        .push_val  (upd_pc + INSN_INC),
        .pop       (accept && kind == BK_RET),
        .top_valid (ras_valid),
        .top_val   (ras_top)
    );

    always_comb begin
        seq_pc       = (fetch_pc & GRP_MASK) + FETCH_INC;
        pred_hit     = btb_hit;
        pred_taken   = ght_taken;
        pred_next_pc = seq_pc;
        if (btb_hit) begin
            if (btb_kind == BK_RET) begin
                pred_taken   = ras_valid;
                pred_next_pc = ras_valid ? ras_top : seq_pc;
            end else begin
                pred_taken   = 1'b1;
                pred_next_pc = btb_target;
            end
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        if (accept && upd_correct != upd_pred_pc) begin
            ctl_d.flush    = 1'b1;
            ctl_d.redirect = upd_correct;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flush       = ctl_q.flush;
    assign redirect_pc = ctl_q.redirect;
endmodule

// File: rtl/bp_next_pc_chk.sv
module bp_next_pc_chk #(
    parameter int PC_W        = 32,
    parameter int FETCH_BYTES = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            pred_taken,
    input logic            pred_hit,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic [PC_W-1:0] upd_pred_pc,
    input logic            flush,
    input logic [PC_W-1:0] redirect_pc
);
    localparam int OFF_W = $clog2(FETCH_BYTES);

    logic [PC_W-1:0] grp_next, resolved;
    assign grp_next = {fetch_pc[PC_W-1:OFF_W], {OFF_W{1'b0}}} + PC_W'(FETCH_BYTES);
    assign resolved = upd_taken ? upd_target : upd_pc + PC_W'(4);

    p_miss_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_next_pc == grp_next);

    p_nottaken_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hit && !pred_taken) |-> pred_next_pc == grp_next);

    p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !flush && resolved != upd_pred_pc)
        |=> (flush && redirect_pc == $past(resolved)));

    p_match_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !flush && resolved == upd_pred_pc) |=> !flush);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> !flush);

    p_flush_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
endmodule

bind bp_next_pc bp_next_pc_chk #(.PC_W(PC_W), .FETCH_BYTES(FETCH_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit),
    .upd_valid    (upd_valid),
    .upd_taken    (upd_taken),
    .upd_pc       (upd_pc),
    .upd_target   (upd_target),
    .upd_pred_pc  (upd_pred_pc),
    .flush        (flush),
    .redirect_pc  (redirect_pc)
);

// File: tb/bp_next_pc_tb_top.sv
module bp_next_pc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic [31:0] pred_next_pc;
    logic        pred_taken, pred_hit;
    logic        upd_valid;
    logic [1:0]  upd_kind;
    logic        upd_taken;
    logic [31:0] upd_pc, upd_target, upd_pred_pc;
    logic        flush;
    logic [31:0] redirect_pc;

    localparam logic [1:0] K_COND = 2'd0, K_CALL = 2'd1, K_RET = 2'd2;

    always #2.5ns clk = ~clk;

    bp_next_pc dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_next_pc(pred_next_pc), .pred_taken(pred_taken), .pred_hit(pred_hit),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_taken(upd_taken),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_pred_pc(upd_pred_pc),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    typedef struct packed {
        logic        uv;
        logic [1:0]  kind;
        logic        tk;
        logic [31:0] upc, utgt, upred, fpc, enext;
        logic        ehit, eflush;
        logic [31:0] eredir;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R2: empty buffer, sequential group
        '{1'b0, K_COND, 1'b0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h1008, 1'b0, 1'b0, 32'h0, 4'd2},
        // R8/R3: taken conditional mispredicted, then hits
        '{1'b1, K_COND, 1'b1, 32'h1000, 32'h2000, 32'h1004, 32'h1000, 32'h2000, 1'b1, 1'b1, 32'h2000, 4'd8},
        // R6: call allocates and pushes 0x1104
        '{1'b1, K_CALL, 1'b1, 32'h1100, 32'h3000, 32'h3000, 32'h1100, 32'h3000, 1'b1, 1'b0, 32'h0, 4'd6},
        // R7: return pops the only entry, empty stack -> sequential
        '{1'b1, K_RET, 1'b1, 32'h3010, 32'h1104, 32'h1104, 32'h3010, 32'h3018, 1'b1, 1'b0, 32'h0, 4'd7},
        // R6: new call, return entry predicts 0x1204
        '{1'b1, K_CALL, 1'b1, 32'h1200, 32'h3000, 32'h3000, 32'h3010, 32'h1204, 1'b1, 1'b0, 32'h0, 4'd6},
        // R4: not-taken conditional hit invalidates, flush to pc+4
        '{1'b1, K_COND, 1'b0, 32'h1000, 32'h2000, 32'h2000, 32'h1000, 32'h1008, 1'b0, 1'b1, 32'h1004, 4'd4},
        // R4: set 0 fills way 0
        '{1'b1, K_COND, 1'b1, 32'h4000, 32'h5000, 32'h5000, 32'h4000, 32'h5000, 1'b1, 1'b0, 32'h0, 4'd4},
        // R4: set 0 fills way 1
        '{1'b1, K_COND, 1'b1, 32'h8000, 32'h9000, 32'h9000, 32'h4000, 32'h5000, 1'b1, 1'b0, 32'h0, 4'd4},
        // R4: hit on 0x4000 makes the 0x8000 way LRU
        '{1'b1, K_COND, 1'b1, 32'h4000, 32'h5000, 32'h5000, 32'h8000, 32'h9000, 1'b1, 1'b0, 32'h0, 4'd4},
        // R4: 0xC000 evicts 0x8000
        '{1'b1, K_COND, 1'b1, 32'hC000, 32'hD000, 32'hD000, 32'h8000, 32'h8008, 1'b0, 1'b0, 32'h0, 4'd4},
        // R4: survivor
        '{1'b0, K_COND, 1'b0, 32'h0, 32'h0, 32'h0, 32'h4000, 32'h5000, 1'b1, 1'b0, 32'h0, 4'd4},
        // R3: newcomer
        '{1'b0, K_COND, 1'b0, 32'h0, 32'h0, 32'h0, 32'hC000, 32'hD000, 1'b1, 1'b0, 32'h0, 4'd3},
        // R8: call mispredicted as sequential
        '{1'b1, K_CALL, 1'b1, 32'h1300, 32'h6000, 32'h1304, 32'h1300, 32'h6000, 1'b1, 1'b1, 32'h6000, 4'd8}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; upd_valid = 1'b0; upd_kind = K_COND; upd_taken = 1'b0;
        upd_pc = '0; upd_target = '0; upd_pred_pc = '0; fetch_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one accepted update, no flush expected afterwards
    task automatic push_upd(input logic [1:0] k, input logic t, input logic [31:0] pc, tgt, pred);
        upd_valid = 1'b1; upd_kind = k; upd_taken = t;
        upd_pc = pc; upd_target = tgt; upd_pred_pc = pred;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: reset state at several addresses
        fetch_pc = 32'h0000_1234; #1;
        check(1, "hit after reset", {31'b0, pred_hit}, 32'd0);
        check(1, "taken after reset", {31'b0, pred_taken}, 32'd0);
        check(1, "flush after reset", {31'b0, flush}, 32'd0);
        check(2, "seq unaligned", pred_next_pc, 32'h0000_1238);
        fetch_pc = 32'hFFFF_FFFC; #1;
        check(2, "seq wrap", pred_next_pc, 32'h0000_0000);

        // table walk: R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            upd_valid = VEC[i].uv; upd_kind = VEC[i].kind; upd_taken = VEC[i].tk;
            upd_pc = VEC[i].upc; upd_target = VEC[i].utgt; upd_pred_pc = VEC[i].upred;
            fetch_pc = VEC[i].fpc;
            @(negedge clk);
            check(int'(VEC[i].req), $sformatf("vec %0d flush", i), {31'b0, flush}, {31'b0, VEC[i].eflush});
            if (VEC[i].eflush)
                check(int'(VEC[i].req), $sformatf("vec %0d redirect", i), redirect_pc, VEC[i].eredir);
            check(int'(VEC[i].req), $sformatf("vec %0d hit", i), {31'b0, pred_hit}, {31'b0, VEC[i].ehit});
            check(int'(VEC[i].req), $sformatf("vec %0d next", i), pred_next_pc, VEC[i].enext);
            upd_valid = 1'b0;
            @(negedge clk);
            check(9, $sformatf("vec %0d flush dropped", i), {31'b0, flush}, 32'd0); // R9
        end

        // R5: history fallback on a miss
        do_reset();
        push_upd(K_COND, 1'b1, 32'h0002_0000, 32'h0003_0000, 32'h0003_0000); // ctr[0] 01->10, ghr=1
        fetch_pc = 32'h0002_0004; #1;                                           // idx 1^1 = 0
        check(5, "miss hint taken", {31'b0, pred_taken}, 32'd1);
        check(5, "miss hint hit", {31'b0, pred_hit}, 32'd0);
        check(5, "miss hint next", pred_next_pc, 32'h0002_0008);
        push_upd(K_COND, 1'b0, 32'h0002_0004, 32'h0, 32'h0002_0008);          // ctr[0] 10->01, ghr=2
        check(5, "not-taken no flush", {31'b0, flush}, 32'd0);
        fetch_pc = 32'h0002_0008; #1;                                           // idx 2^2 = 0
        check(5, "miss hint not taken", {31'b0, pred_taken}, 32'd0);

        // R6 R7: stack overflow and underflow
        do_reset();
        push_upd(K_RET, 1'b1, 32'h0005_0000, 32'h0, 32'h0);
        fetch_pc = 32'h0005_0000; #1;
        check(7, "empty stack seq", pred_next_pc, 32'h0005_0008);
        check(7, "empty stack not taken", {31'b0, pred_taken}, 32'd0);
        for (int k = 1; k <= 9; k++)
            push_upd(K_CALL, 1'b1, 32'h0006_0000 + 32'(k) * 32'h10, 32'h0007_0000, 32'h0007_0000);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] ret_to;
            ret_to = 32'h0006_0000 + 32'(9 - i) * 32'h10 + 32'd4;
            fetch_pc = 32'h0005_0000; #1;
            check(6, $sformatf("stack pop %0d", i), pred_next_pc, ret_to);
            push_upd(K_RET, 1'b1, 32'h0005_0000, ret_to, ret_to);
        end
        fetch_pc = 32'h0005_0000; #1;
        check(7, "oldest overwritten", pred_next_pc, 32'h0005_0008);

        // R9: update during flush cycle is ignored
        do_reset();
        upd_valid = 1'b1; upd_kind = K_COND; upd_taken = 1'b1;
        upd_pc = 32'h0008_0000; upd_target = 32'h0008_1000; upd_pred_pc = 32'h0008_0004;
        @(negedge clk);
        check(8, "flush raised", {31'b0, flush}, 32'd1);
        check(8, "redirect", redirect_pc, 32'h0008_1000);
        upd_pc = 32'h0009_0000; upd_target = 32'h0009_1000; upd_pred_pc = 32'h0009_0004;
        @(negedge clk);
        upd_valid = 1'b0;
        check(9, "flush one cycle", {31'b0, flush}, 32'd0);
        fetch_pc = 32'h0009_0000; #1;
        check(9, "ignored update not stored", {31'b0, pred_hit}, 32'd0);
        fetch_pc = 32'h0008_0000; #1;
        check(9, "accepted update stored", pred_next_pc, 32'h0008_1000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule